// File: doc/BRIEF.md
# Multiplexed Boot ROM Bus Controller

This block sits on the host side of an asynchronous 8-bit parallel bus that is shared by a mask ROM and a flash device. A CPU-side agent presents one read or write request at a time, 1, 2 or 4 bytes wide. The controller carries each request out as a series of byte cycles. Each byte cycle has a programmable address-setup count, strobe-width count and hold count, so slow devices with access times of several hundred nanoseconds can be met at any clock rate.

The 21-bit ROM address does not have its own bus. Its low byte goes out on the upper half of the data pins. Three more pin groups carry bits [10:8], [18:11] and [20:19]. The [18:11] group is bidirectional. Right after reset the controller leaves it undriven and reads an 8-bit board mode code from it, and it accepts no request until that code has been captured.

Top module: `romflash_bus_ctrl`

## Requirements
- R1: The address of byte k of a request is base+k, computed modulo 2^21, so accesses wrap at the top of the 2 MB space.
- R2: The request size code selects the number of byte cycles: 00 gives 1, 01 gives 2, and 10 or 11 give 4. Byte k of a read lands in rdata[8k+7:8k] (little-endian), and rdata bytes that are not read return zero. Byte k of a write is taken from wdata[8k+7:8k].
- R3: A request is accepted on a clock edge where req_valid is high and busy is low. From the next cycle, busy stays high for N*(S+W+H+3) cycles, where N is the byte count and S, W, H are the setup, strobe and hold counts. Then comes exactly one cycle with done high and busy low. A request presented while busy is high is ignored.
- R4: Each byte cycle has three parts: S+1 cycles with the chip select low and the strobe high, then W+1 cycles with the strobe low, then H+1 cycles with the strobe high again. The chip select stays low from the start of the first byte cycle to the end of the last. S, W and H are taken at acceptance, and later changes on the timing inputs have no effect on a request already in progress.
- R5: Read data is sampled from pin_d_i in the last strobe-low cycle of each byte.
- R6: Address bits [7:0] appear on pin_adlo_o, [10:8] on pin_amid_o, [18:11] on pin_amode_o and [20:19] on pin_ahi_o. pin_addr_oe is high exactly during byte cycles.
- R7: Target 0 selects pin_rom_cs_n and target 1 selects pin_flash_cs_n. Reads pulse pin_rd_n. Flash writes pulse pin_wr_n and drive pin_d_oe for the whole access. A write aimed at the ROM keeps its timing but pulses neither strobe and never drives data.
- R8: After reset release, with the address drivers off, pin_amode_i is latched into mode_code on the MODE_SETTLE-th clock edge, and mode_valid rises at that same edge. After that, mode_code stays fixed until the next reset.
- R9: While mode_valid is low, busy is high, and no request is accepted and no chip select is asserted.
- R10: During reset, both chip selects and both strobes are high, all output enables are low, done is low, busy is high and mode_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_target | input | 1 | 0 = ROM, 1 = flash |
| req_size | input | 2 | Size code: 00 = 1 byte, 01 = 2 bytes, 1x = 4 bytes |
| req_addr | input | 21 | Byte address of the first byte |
| req_wdata | input | 32 | Write data, little-endian |
| cfg_setup | input | CNT_W | Setup count S |
| cfg_strobe | input | CNT_W | Strobe-width count W |
| cfg_hold | input | CNT_W | Hold count H |
| busy | output | 1 | Request in progress or mode capture pending |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read data |
| mode_valid | output | 1 | Mode code has been captured |
| mode_code | output | 8 | Captured board mode code |
| pin_d_o | output | 8 | Lower data pins, outgoing |
| pin_d_i | input | 8 | Lower data pins, incoming |
| pin_d_oe | output | 1 | Lower data pin drive enable |
| pin_adlo_o | output | 8 | Upper data pins carrying address [7:0] |
| pin_amid_o | output | 3 | Address [10:8] |
| pin_amode_o | output | 8 | Address [18:11] on the shared mode pins |
| pin_amode_i | input | 8 | Shared mode pins, incoming |
| pin_ahi_o | output | 2 | Address [20:19] |
| pin_addr_oe | output | 1 | Drive enable for the address groups |
| pin_rom_cs_n | output | 1 | ROM select, active low |
| pin_flash_cs_n | output | 1 | Flash select, active low |
| pin_rd_n | output | 1 | Read strobe, active low |
| pin_wr_n | output | 1 | Write strobe, active low |

## Verification
The completion of one request and the acceptance of the next can fall in the same cycle. The done cycle has busy low, so a request already waiting on the inputs is taken at the edge that ends done. The bench provokes this by issuing the next request in the very cycle done appears, across long runs of random ROM and flash accesses. It judges the result by checking that the new request shows exactly S+1 setup cycles and the full busy length, and that its data is correct. A related case is a request raised in the middle of an access. It must be dropped, and the bench confirms this by reading back the flash location that request would have written.

// File: rtl/bootbus_pkg.sv
package bootbus_pkg;

    localparam int ADDR_W     = 21;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int IDX_W      = $clog2(WORD_BYTES);
    localparam int LO_W       = 8;
    localparam int MID_W      = 3;
    localparam int MODE_W     = 8;
    localparam int HI_W       = ADDR_W - LO_W - MID_W - MODE_W;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef enum logic {
        TGT_ROM   = 1'b0,
        TGT_FLASH = 1'b1
    } target_e;

    typedef struct packed {
        logic              write;
        target_e           target;
        logic [IDX_W-1:0]  last_idx;
        logic [ADDR_W-1:0] base;
        logic [WORD_W-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [MODE_W-1:0] modegrp;
        logic [MID_W-1:0]  mid;
        logic [LO_W-1:0]   lo;
    } addr_pins_t;

    // size code to index of the last byte
    function automatic logic [IDX_W-1:0] size_last(input logic [1:0] sz);
        case (sz)
            2'b00:   return IDX_W'(0);
            2'b01:   return IDX_W'(1);
            default: return IDX_W'(WORD_BYTES - 1);
        endcase
    endfunction

    function automatic addr_pins_t split_addr(input logic [ADDR_W-1:0] a);
        addr_pins_t p;
        p.lo      = a[LO_W-1:0];
        p.mid     = a[LO_W+MID_W-1:LO_W];
        p.modegrp = a[LO_W+MID_W+MODE_W-1:LO_W+MID_W];
        p.hi      = a[ADDR_W-1:LO_W+MID_W+MODE_W];
        return p;
    endfunction

endpackage

// File: rtl/boot_mode_sampler.sv
module boot_mode_sampler #(
    parameter int SETTLE = 6,
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] pins_i,
    output logic [CODE_W-1:0] code_o,
    output logic              valid_o
);
    localparam int CW = $clog2(SETTLE + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            code_o  <= '0;
            valid_o <= 1'b0;
        end else if (!valid_o) begin
            if (cnt == CW'(SETTLE - 1)) begin
                code_o  <= pins_i;
                valid_o <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R8: once captured, the code never moves until reset
    assert_mode_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> (valid_o && $stable(code_o)));

endmodule

// File: rtl/byte_cycle_engine.sv
module byte_cycle_engine
    import bootbus_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] t_setup,
    input  logic [CNT_W-1:0] t_strobe,
    input  logic [CNT_W-1:0] t_hold,
    output phase_e           phase_o,
    output logic             strobe_last,
    output logic             byte_last
);
    phase_e           phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (start) begin
            phase <= PH_SETUP;
            cnt   <= t_setup;
        end else begin
            case (phase)
                PH_SETUP: begin
                    if (cnt == '0) begin
                        phase <= PH_STROBE;
                        cnt   <= t_strobe;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (cnt == '0) begin
                        phase <= PH_HOLD;
                        cnt   <= t_hold;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign phase_o     = phase;
    assign strobe_last = (phase == PH_STROBE) && (cnt == '0);
    assign byte_last   = (phase == PH_HOLD) && (cnt == '0);

    // R4: a strobe window is always entered from the setup part
    assert_strobe_after_setup_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STROBE && $past(phase) != PH_STROBE) |-> ($past(phase) == PH_SETUP));

    // R4: the hold part always follows a strobe window
    assert_hold_after_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD && $past(phase) != PH_HOLD) |-> ($past(phase) == PH_STROBE));

endmodule

// File: rtl/rom_pin_mapper.sv
module rom_pin_mapper
    import bootbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  req_t              req,
    input  logic [IDX_W-1:0]  byte_idx,
    output logic [BYTE_W-1:0] d_o,
    output logic              d_oe,
    output logic [LO_W-1:0]   adlo_o,
    output logic [MID_W-1:0]  amid_o,
    output logic [MODE_W-1:0] amode_o,
    output logic [HI_W-1:0]   ahi_o,
    output logic              addr_oe,
    output logic              rom_cs_n,
    output logic              flash_cs_n,
    output logic              rd_n,
    output logic              wr_n
);
    logic              active;
    logic              in_strobe;
    logic [ADDR_W-1:0] cur_addr;
    addr_pins_t        ap;

    assign active    = (phase != PH_IDLE);
    assign in_strobe = (phase == PH_STROBE);
    assign cur_addr  = req.base + ADDR_W'(byte_idx);
    assign ap        = split_addr(cur_addr);

    assign adlo_o  = ap.lo;
    assign amid_o  = ap.mid;
    assign amode_o = ap.modegrp;
    assign ahi_o   = ap.hi;
    assign addr_oe = active;

    assign rom_cs_n   = !(active && req.target == TGT_ROM);
    assign flash_cs_n = !(active && req.target == TGT_FLASH);
    assign rd_n       = !(in_strobe && !req.write);
    assign wr_n       = !(in_strobe && req.write && req.target == TGT_FLASH);
    assign d_oe       = active && req.write && (req.target == TGT_FLASH);
    assign d_o        = req.wdata[{byte_idx, 3'b000} +: BYTE_W];

    // R7: a strobe is never issued without one device selected
    assert_strobe_in_select_R7: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> (rom_cs_n != flash_cs_n));

    // R7: the ROM never sees a write strobe or driven data
    assert_rom_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        !rom_cs_n |-> (wr_n && !d_oe));

    // R6: address pins are driven whenever a device is selected
    assert_addr_driven_R6: assert property (@(posedge clk) disable iff (rst)
        (!rom_cs_n || !flash_cs_n) |-> addr_oe);

endmodule

// File: rtl/romflash_bus_ctrl.sv
module romflash_bus_ctrl
    import bootbus_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int MODE_SETTLE = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_target,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_strobe,
    input  logic [CNT_W-1:0]  cfg_hold,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rdata,
    output logic              mode_valid,
    output logic [MODE_W-1:0] mode_code,
    output logic [BYTE_W-1:0] pin_d_o,
    input  logic [BYTE_W-1:0] pin_d_i,
    output logic              pin_d_oe,
    output logic [LO_W-1:0]   pin_adlo_o,
    output logic [MID_W-1:0]  pin_amid_o,
    output logic [MODE_W-1:0] pin_amode_o,
    input  logic [MODE_W-1:0] pin_amode_i,
    output logic [HI_W-1:0]   pin_ahi_o,
    output logic              pin_addr_oe,
    output logic              pin_rom_cs_n,
    output logic              pin_flash_cs_n,
    output logic              pin_rd_n,
    output logic              pin_wr_n
);
    req_t              req_q;
    logic [CNT_W-1:0]  t_setup_q, t_strobe_q, t_hold_q;
    logic [IDX_W-1:0]  byte_idx;
    logic              run_q;
    logic              done_q;
    logic [WORD_W-1:0] rdata_q;
    logic              accept;
    logic              final_byte;
    logic              start;
    phase_e            phase;
    logic              strobe_last;
    logic              byte_last;

    boot_mode_sampler #(
        .SETTLE (MODE_SETTLE),
        .CODE_W (MODE_W)
    ) u_mode (
        .clk     (clk),
        .rst     (rst),
        .pins_i  (pin_amode_i),
        .code_o  (mode_code),
        .valid_o (mode_valid)
    );

    assign busy       = !mode_valid || run_q;
    assign accept     = req_valid && !busy;
    assign final_byte = (byte_idx == req_q.last_idx);
    assign start      = accept || (byte_last && !final_byte);

    byte_cycle_engine #(
        .CNT_W (CNT_W)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .t_setup     (accept ? cfg_setup  : t_setup_q),
        .t_strobe    (t_strobe_q),
        .t_hold      (t_hold_q),
        .phase_o     (phase),
        .strobe_last (strobe_last),
        .byte_last   (byte_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q      <= '0;
            t_setup_q  <= '0;
            t_strobe_q <= '0;
            t_hold_q   <= '0;
            byte_idx   <= '0;
            run_q      <= 1'b0;
            done_q     <= 1'b0;
            rdata_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                req_q.write    <= req_write;
                req_q.target   <= target_e'(req_target);
                req_q.last_idx <= size_last(req_size);
                req_q.base     <= req_addr;
                req_q.wdata    <= req_wdata;
                t_setup_q      <= cfg_setup;
                t_strobe_q     <= cfg_strobe;
                t_hold_q       <= cfg_hold;
                byte_idx       <= '0;
                run_q          <= 1'b1;
                rdata_q        <= '0;
            end else if (run_q) begin
                if (strobe_last && !req_q.write) begin
                    rdata_q[{byte_idx, 3'b000} +: BYTE_W] <= pin_d_i;
                end
                if (byte_last) begin
                    if (final_byte) begin
                        run_q  <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        byte_idx <= byte_idx + 1'b1;
                    end
                end
            end
        end
    end

    assign done  = done_q;
    assign rdata = rdata_q;

    rom_pin_mapper u_pins (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .req        (req_q),
        .byte_idx   (byte_idx),
        .d_o        (pin_d_o),
        .d_oe       (pin_d_oe),
        .adlo_o     (pin_adlo_o),
        .amid_o     (pin_amid_o),
        .amode_o    (pin_amode_o),
        .ahi_o      (pin_ahi_o),
        .addr_oe    (pin_addr_oe),
        .rom_cs_n   (pin_rom_cs_n),
        .flash_cs_n (pin_flash_cs_n),
        .rd_n       (pin_rd_n),
        .wr_n       (pin_wr_n)
    );

    // R9: no bus activity before the mode code is in
    assert_quiet_before_mode_R9: assert property (@(posedge clk) disable iff (rst)
        !mode_valid |-> (phase == PH_IDLE && !pin_addr_oe));

    // R3: completion is a single-cycle pulse
    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: the engine is idle whenever completion is reported
    assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (phase == PH_IDLE));

endmodule

// File: tb/tb_romflash_bus_ctrl.sv
module tb_romflash_bus_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 6;
    localparam int CW         = 4;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_target = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [20:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [CW-1:0] cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0;
    logic        busy, done, mode_valid;
    logic [31:0] rdata;
    logic [7:0]  mode_code, pin_d_o, pin_d_i, pin_adlo_o, pin_amode_o, pin_amode_i;
    logic [2:0]  pin_amid_o;
    logic [1:0]  pin_ahi_o;
    logic        pin_d_oe, pin_addr_oe, pin_rom_cs_n, pin_flash_cs_n, pin_rd_n, pin_wr_n;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [7:0]  mode_pins = 8'hA5;
    logic [7:0]  fmem   [256];
    logic [7:0]  shadow [256];
    logic [20:0] bus_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    romflash_bus_ctrl #(.CNT_W(CW), .MODE_SETTLE(SETTLE)) dut (.*);

    function automatic logic [7:0] rom_byte(input logic [20:0] a);
        return a[7:0] ^ a[15:8] ^ {a[20:16], a[20:18]} ^ 8'h3C;
    endfunction

    assign bus_addr    = {pin_ahi_o, pin_amode_o, pin_amid_o, pin_adlo_o};
    assign pin_amode_i = pin_addr_oe ? pin_amode_o : mode_pins;
    assign pin_d_i     = (!pin_addr_oe)                   ? 8'hEE :
                         (!pin_rd_n && !pin_rom_cs_n)     ? rom_byte(bus_addr) :
                         (!pin_rd_n && !pin_flash_cs_n)   ? fmem[bus_addr[7:0]] : 8'h00;

    always @(posedge pin_wr_n) begin
        if (pin_flash_cs_n === 1'b0 && pin_d_oe === 1'b1) fmem[bus_addr[7:0]] = pin_d_o;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    endfunction

    // issue one request and measure it at the pins; poke raises a stray request mid-access
    task automatic issue(input bit wr, input bit tgt, input logic [1:0] sz, input logic [20:0] a,
                         input logic [31:0] wd, input int s, input int w, input int h,
                         input bit poke, output logic [31:0] rd);
        int n, exp_busy, busy_cnt, str_cnt, falls, pre, oe_cnt, aoe_cnt;
        bit prev_low, strobe_exp;
        while (busy) @(negedge clk);
        req_write = wr; req_target = tgt; req_size = sz; req_addr = a; req_wdata = wd;
        cfg_setup = CW'(s); cfg_strobe = CW'(w); cfg_hold = CW'(h);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_setup = CW'($urandom); cfg_strobe = CW'($urandom); cfg_hold = CW'($urandom);
        n = nbytes(sz);
        exp_busy = n * (s + w + h + 3);
        strobe_exp = !wr || tgt;
        busy_cnt = 0; str_cnt = 0; falls = 0; pre = 0; oe_cnt = 0; aoe_cnt = 0; prev_low = 0;
        while (busy && busy_cnt < 1000) begin
            if (poke && busy_cnt == 1) begin
                req_valid = 1'b1; req_write = 1'b1; req_target = 1'b1;
                req_size = 2'b00; req_addr = 21'h000077; req_wdata = 32'hDD;
            end
            if (poke && busy_cnt == 2) req_valid = 1'b0;
            busy_cnt++;
            if ((tgt ? pin_flash_cs_n : pin_rom_cs_n) == 1'b0) begin
                if (!(pin_rd_n && pin_wr_n)) begin
                    str_cnt++;
                    if (!prev_low) falls++;
                end else if (falls == 0) pre++;
            end
            prev_low = !(pin_rd_n && pin_wr_n);
            if (pin_d_oe) oe_cnt++;
            if (pin_addr_oe) aoe_cnt++;
            @(negedge clk);
        end
        rd = rdata;
        check(busy_cnt == exp_busy, "R3 busy length", busy_cnt, exp_busy);
        check(done === 1'b1 && busy === 1'b0, "R3 done pulse", {done, busy}, 2'b10);
        check(str_cnt == (strobe_exp ? n * (w + 1) : 0), "R4/R7 strobe cycles", str_cnt,
              strobe_exp ? n * (w + 1) : 0);
        check(falls == (strobe_exp ? n : 0), "R4 strobe count", falls, strobe_exp ? n : 0);
        if (strobe_exp) check(pre == s + 1, "R4 setup cycles", pre, s + 1);
        check(oe_cnt == ((wr && tgt) ? exp_busy : 0), "R7 data drive", oe_cnt,
              (wr && tgt) ? exp_busy : 0);
        check(aoe_cnt == exp_busy && !pin_addr_oe, "R6 address enable", aoe_cnt, exp_busy);
    endtask

    task automatic do_read(input bit tgt, input logic [1:0] sz, input logic [20:0] a,
                           input int s, input int w, input int h, input string tag);
        logic [31:0] got, exp;
        exp = '0;
        for (int k = 0; k < nbytes(sz); k++) begin
            logic [20:0] ak;
            ak = a + 21'(k);
            exp[8*k +: 8] = tgt ? shadow[ak[7:0]] : rom_byte(ak);
        end
        issue(1'b0, tgt, sz, a, 32'h0, s, w, h, 1'b0, got);
        check(got == exp, tag, got, exp);
    endtask

    task automatic do_write(input bit tgt, input logic [1:0] sz, input logic [20:0] a,
                            input logic [31:0] wd, input int s, input int w, input int h, input bit poke);
        logic [31:0] got;
        issue(1'b1, tgt, sz, a, wd, s, w, h, poke, got);
        if (tgt) begin
            for (int k = 0; k < nbytes(sz); k++) begin
                logic [20:0] ak;
                ak = a + 21'(k);
                shadow[ak[7:0]] = wd[8*k +: 8];
            end
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int cs_seen;
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) begin
            fmem[i] = 8'(i) ^ 8'h5A;
            shadow[i] = 8'(i) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        // R10 reset state
        check(pin_rom_cs_n && pin_flash_cs_n && pin_rd_n && pin_wr_n && !pin_d_oe && !pin_addr_oe
              && !done && busy && !mode_valid, "R10 reset state",
              {pin_rom_cs_n, pin_flash_cs_n, pin_rd_n, pin_wr_n, pin_d_oe, pin_addr_oe, done, busy, mode_valid},
              9'b111100010);
        // R9: request held during mode capture must be ignored
        req_valid = 1'b1; req_write = 1'b1; req_target = 1'b1; req_addr = 21'h10; req_wdata = 32'hEE;
        rst = 1'b0;
        cs_seen = 0;
        for (int i = 0; i < SETTLE - 1; i++) begin
            @(negedge clk);
            if (!pin_rom_cs_n || !pin_flash_cs_n) cs_seen++;
        end
        req_valid = 1'b0;
        check(!mode_valid && busy, "R8 mode not yet captured", {mode_valid, busy}, 2'b01);
        check(cs_seen == 0, "R9 no select before mode", cs_seen, 0);
        @(negedge clk);
        check(mode_valid && mode_code == 8'hA5, "R8 mode capture", {mode_valid, mode_code}, {1'b1, 8'hA5});
        mode_pins = 8'h3C;
        @(negedge clk);
        do_read(1'b1, 2'b00, 21'h10, 0, 0, 0, "R9 held request not accepted");

        // directed corner cases
        do_read(1'b0, 2'b00, 21'h0ABCD, 1, 2, 1, "R2 one byte, upper zero");
        do_read(1'b0, 2'b10, 21'h1FFFFE, 0, 1, 0, "R1 wrap at top");
        do_read(1'b0, 2'b11, 21'h155AA5, 2, 0, 3, "R2 size 11 is four bytes");
        do_read(1'b0, 2'b01, 21'h0F807F, 3, 3, 3, "R6 pin mapping");
        do_write(1'b1, 2'b10, 21'h000040, 32'h44332211, 1, 1, 1, 1'b0);
        do_read(1'b1, 2'b10, 21'h000040, 0, 0, 0, "R2 flash little-endian");
        do_read(1'b1, 2'b01, 21'h000041, 0, 2, 0, "R5 flash partial read");
        do_write(1'b0, 2'b10, 21'h000040, 32'hFFFFFFFF, 0, 1, 0, 1'b0);
        do_read(1'b1, 2'b10, 21'h000040, 0, 0, 0, "R7 ROM write leaves flash");
        do_write(1'b1, 2'b00, 21'h000020, 32'h000000C3, 2, 2, 2, 1'b1);
        do_read(1'b1, 2'b00, 21'h000077, 0, 0, 0, "R3 request during busy ignored");
        do_read(1'b1, 2'b00, 21'h000020, 0, 0, 0, "R3 write before stray request");
        check(mode_code == 8'hA5, "R8 mode code frozen", mode_code, 8'hA5);

        // constrained random traffic, issued back to back
        for (int t = 0; t < 120; t++) begin
            int op;
            logic [1:0]  sz;
            logic [20:0] a;
            op = int'($urandom % 8);
            sz = 2'($urandom);
            a  = 21'($urandom);
            if (op < 3)       do_read(1'b0, sz, a, int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), "R2 random ROM read");
            else if (op < 5)  do_write(1'b1, sz, a, $urandom, int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), 1'b0);
            else if (op < 7)  do_read(1'b1, sz, a, int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), "R5 random flash read");
            else              do_write(1'b0, sz, a, $urandom, int'($urandom % 4), int'($urandom % 4), int'($urandom % 4), 1'b0);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule